// File: doc/BRIEF.md
# Clock Phase Tap Delay Programmer

This block turns a pair of requested clock phases, given in degrees from 0 to 359, into tap-delay codes for an SD host's receive sample clock and transmit card clock. The number of taps that span one clock period depends on the bus timing mode. The block looks that count up, scales each phase by it with truncating integer arithmetic, and writes the resulting codes into an input tap-delay register and an output tap-delay register. Each register is updated through a fixed, safe sequence of single-field writes.

A request is one transfer on a valid/ready interface. The transfer carries the timing mode, both phases and a flag that says whether the host controller is of a version that supports phase programming. `req_ready` is high only while the block is idle. A request that is presented while `req_ready` is low is not taken and has no effect. The requester may hold `req_valid` high and keep the payload stable until `req_ready` rises. The transfer is accepted on the first rising edge where both signals are high.

After acceptance, a serial divider runs for 16 cycles. The input register is then programmed, followed by the output register, and `done` pulses once. The delay line and the DLL that consume the register fields are outside this block.

Top module: `tapdly_prog`

## Requirements
- R1: After reset, `in_reg` and `out_reg` are zero, `busy` and `done` are low and `req_ready` is high.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` equals the inverse of `busy`. `busy` is high from the acceptance edge until the sequence ends. A request presented while `req_ready` is low is ignored and leaves both registers unchanged.
- R3: Timing mode codes are: 0 legacy, 1 MMC high speed, 2 SD high speed, 3 SDR12, 4 SDR25, 5 SDR50, 6 SDR104, 7 DDR50, 8 DDR52, 9 HS200, 10 HS400. The output path uses 30 taps in modes 1, 2, 4, 7 and 8, 15 taps in mode 5, and 8 taps in modes 6 and 9.
- R4: The input path uses 120 taps in modes 1, 2, 4, 7 and 8, 60 taps in mode 5, and 30 taps in modes 6 and 9.
- R5: Every other mode code (0, 3 and 10 to 15) uses 0 taps, so both codes are 0.
- R6: Each code equals floor(degrees × taps / 360). The input code is kept to 8 bits and the output code to 6 bits.
- R7: `in_reg` holds a change-window bit at bit 9, an enable bit at bit 8 and the select code at bits 7:0. The acceptance edge is counted as edge 0. Bit 9 sets at edge 18, bit 8 sets at edge 19, bits 7:0 take the new code at edge 20, and bit 9 clears at edge 21. The select field changes only while bit 9 is set.
- R8: `out_reg` holds an enable bit at bit 6 and the select code at bits 5:0. Bit 6 sets at edge 22 and bits 5:0 take the new code at edge 23, after the input window has closed.
- R9: If the version flag is low at acceptance, neither register changes. `done` is then high in the cycle after edge 17 and `busy` drops at edge 18.
- R10: With the version flag high, `done` is high for exactly one cycle, after edge 23, and `busy` drops at edge 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_mode | input | 4 | Timing mode code |
| req_in_deg | input | 9 | Receive sample clock phase in degrees |
| req_out_deg | input | 9 | Transmit card clock phase in degrees |
| req_ver_ok | input | 1 | Controller version supports phase programming |
| in_reg | output | 10 | Input tap-delay register: window, enable, select |
| out_reg | output | 7 | Output tap-delay register: enable, select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can fall in the same cycle: the end-of-sequence pulse on `done` and a newly presented request. The bench provokes this by raising `req_valid` with a fresh payload during the `done` cycle and holding it there. The request must not be taken on the edge that closes the sequence. It must be taken on the following edge, and its codes must replace the earlier ones. The same judgement applies to requests that arrive in the middle of a sequence: the registers must end up with the codes of the first request only.

// File: rtl/tapdly_pkg.sv
package tapdly_pkg;

  localparam int MODE_W  = 4;
  localparam int DEG_W   = 9;
  localparam int TMAX_W  = 7;
  localparam int PROD_W  = DEG_W + TMAX_W;
  localparam int DEG_DEN = 360;
  localparam int ICODE_W = 8;
  localparam int OCODE_W = 6;

  localparam logic [MODE_W-1:0] MD_LEGACY = 4'd0;
  localparam logic [MODE_W-1:0] MD_MMC_HS = 4'd1;
  localparam logic [MODE_W-1:0] MD_SD_HS  = 4'd2;
  localparam logic [MODE_W-1:0] MD_SDR12  = 4'd3;
  localparam logic [MODE_W-1:0] MD_SDR25  = 4'd4;
  localparam logic [MODE_W-1:0] MD_SDR50  = 4'd5;
  localparam logic [MODE_W-1:0] MD_SDR104 = 4'd6;
  localparam logic [MODE_W-1:0] MD_DDR50  = 4'd7;
  localparam logic [MODE_W-1:0] MD_DDR52  = 4'd8;
  localparam logic [MODE_W-1:0] MD_HS200  = 4'd9;
  localparam logic [MODE_W-1:0] MD_HS400  = 4'd10;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CALC,
    SQ_IN_WIN,
    SQ_IN_EN,
    SQ_IN_SEL,
    SQ_IN_CLOSE,
    SQ_OUT_EN,
    SQ_OUT_SEL,
    SQ_FIN
  } seq_state_e;

endpackage

// File: rtl/tapdly_mode_lut.sv
module tapdly_mode_lut
  import tapdly_pkg::*;
#(
  parameter int IN_TAPS_50  = 120,
  parameter int IN_TAPS_100 = 60,
  parameter int IN_TAPS_200 = 30,
  parameter int OUT_TAPS_50  = 30,
  parameter int OUT_TAPS_100 = 15,
  parameter int OUT_TAPS_200 = 8
) (
  input  logic [MODE_W-1:0] mode,
  output logic [TMAX_W-1:0] in_taps,
  output logic [TMAX_W-1:0] out_taps
);

  typedef enum logic [1:0] {GRP_NONE, GRP_50, GRP_100, GRP_200} speed_grp_e;

  speed_grp_e grp;

  // Classify the mode by its card clock rate.
  always_comb begin
    unique case (mode)
      MD_MMC_HS, MD_SD_HS, MD_SDR25, MD_DDR50, MD_DDR52: grp = GRP_50;
      MD_SDR50:                                          grp = GRP_100;
      MD_SDR104, MD_HS200:                               grp = GRP_200;
      default:                                           grp = GRP_NONE;
    endcase
  end

  always_comb begin
    unique case (grp)
      GRP_50: begin
        in_taps  = TMAX_W'(IN_TAPS_50);
        out_taps = TMAX_W'(OUT_TAPS_50);
      end
      GRP_100: begin
        in_taps  = TMAX_W'(IN_TAPS_100);
        out_taps = TMAX_W'(OUT_TAPS_100);
      end
      GRP_200: begin
        in_taps  = TMAX_W'(IN_TAPS_200);
        out_taps = TMAX_W'(OUT_TAPS_200);
      end
      default: begin
        in_taps  = '0;
        out_taps = '0;
      end
    endcase
  end

endmodule

// File: rtl/tapdly_divider.sv
module tapdly_divider #(
  parameter int NUM_W = 16,
  parameter int DEN   = 360,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  output logic [OUT_W-1:0] quo,
  output logic             rdy
);

  localparam int REM_W = $clog2(DEN) + 1;
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int MAX_Q = ((2 ** NUM_W) - 1) / DEN;

  logic [NUM_W-1:0] acc;
  logic [REM_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic [REM_W:0]   trial;
  logic             qbit;
  logic [REM_W-1:0] rem_nxt;

  // One restoring step per cycle: bring in the next dividend bit.
  always_comb begin
    trial = {rem, acc[NUM_W-1]};
    qbit  = (trial >= (REM_W+1)'(DEN));
    if (qbit) rem_nxt = REM_W'(trial - (REM_W+1)'(DEN));
    else      rem_nxt = trial[REM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      rem <= '0;
      cnt <= '0;
    end else if (start) begin
      acc <= num;
      rem <= '0;
      cnt <= CNT_W'(NUM_W);
    end else if (cnt != '0) begin
      acc <= {acc[NUM_W-2:0], qbit};
      rem <= rem_nxt;
      cnt <= cnt - 1'b1;
    end
  end

  assign quo = acc[OUT_W-1:0];
  assign rdy = (cnt == '0);

  AST_QUO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (acc <= NUM_W'(MAX_Q))); // R6

  AST_CNT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == CNT_W'(NUM_W))); // R2

endmodule

// File: rtl/tapdly_seq.sv
module tapdly_seq
  import tapdly_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               ver_ok,
  input  logic               div_rdy,
  input  logic [ICODE_W-1:0] in_code,
  input  logic [OCODE_W-1:0] out_code,
  output logic               in_win,
  output logic               in_en,
  output logic [ICODE_W-1:0] in_sel,
  output logic               out_en,
  output logic [OCODE_W-1:0] out_sel,
  output logic               busy,
  output logic               done
);

  seq_state_e state;
  logic       ver_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      ver_lat <= 1'b0;
      in_win  <= 1'b0;
      in_en   <= 1'b0;
      in_sel  <= '0;
      out_en  <= 1'b0;
      out_sel <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (accept) begin
            state   <= SQ_CALC;
            ver_lat <= ver_ok;
          end
        end
        SQ_CALC: begin
          if (div_rdy) state <= ver_lat ? SQ_IN_WIN : SQ_FIN;
        end
        SQ_IN_WIN: begin
          in_win <= 1'b1;
          state  <= SQ_IN_EN;
        end
        SQ_IN_EN: begin
          in_en <= 1'b1;
          state <= SQ_IN_SEL;
        end
        SQ_IN_SEL: begin
          in_sel <= in_code;
          state  <= SQ_IN_CLOSE;
        end
        SQ_IN_CLOSE: begin
          in_win <= 1'b0;
          state  <= SQ_OUT_EN;
        end
        SQ_OUT_EN: begin
          out_en <= 1'b1;
          state  <= SQ_OUT_SEL;
        end
        SQ_OUT_SEL: begin
          out_sel <= out_code;
          state   <= SQ_FIN;
        end
        SQ_FIN: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);
  assign done = (state == SQ_FIN);

  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_sel) |-> in_win); // R7

  AST_OUT_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_sel) |-> (out_en && !in_win)); // R8

  AST_NOVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_win) |-> ver_lat); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

// File: rtl/tapdly_prog.sv
module tapdly_prog
  import tapdly_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [3:0]   req_mode,
  input  logic [8:0]   req_in_deg,
  input  logic [8:0]   req_out_deg,
  input  logic         req_ver_ok,
  output logic [9:0]   in_reg,
  output logic [6:0]   out_reg,
  output logic         busy,
  output logic         done
);

  logic [TMAX_W-1:0]  in_taps;
  logic [TMAX_W-1:0]  out_taps;
  logic [PROD_W-1:0]  in_prod;
  logic [PROD_W-1:0]  out_prod;
  logic [ICODE_W-1:0] in_code;
  logic [OCODE_W-1:0] out_code;
  logic               in_rdy;
  logic               out_rdy;
  logic               accept;
  logic               in_win;
  logic               in_en;
  logic [ICODE_W-1:0] in_sel;
  logic               out_en;
  logic [OCODE_W-1:0] out_sel;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  tapdly_mode_lut u_lut (
    .mode     (req_mode),
    .in_taps  (in_taps),
    .out_taps (out_taps)
  );

  assign in_prod  = PROD_W'(req_in_deg)  * PROD_W'(in_taps);
  assign out_prod = PROD_W'(req_out_deg) * PROD_W'(out_taps);

  tapdly_divider #(.NUM_W(PROD_W), .DEN(DEG_DEN), .OUT_W(ICODE_W)) u_div_in (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .num   (in_prod),
    .quo   (in_code),
    .rdy   (in_rdy)
  );

  tapdly_divider #(.NUM_W(PROD_W), .DEN(DEG_DEN), .OUT_W(OCODE_W)) u_div_out (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .num   (out_prod),
    .quo   (out_code),
    .rdy   (out_rdy)
  );

  tapdly_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .ver_ok   (req_ver_ok),
    .div_rdy  (in_rdy && out_rdy),
    .in_code  (in_code),
    .out_code (out_code),
    .in_win   (in_win),
    .in_en    (in_en),
    .in_sel   (in_sel),
    .out_en   (out_en),
    .out_sel  (out_sel),
    .busy     (busy),
    .done     (done)
  );

  assign in_reg  = {in_win, in_en, in_sel};
  assign out_reg = {out_en, out_sel};

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R2

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R2

endmodule

// File: tb/tapdly_prog_bench.sv
module tapdly_prog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_mode = '0;
  logic [8:0] req_in_deg = '0;
  logic [8:0] req_out_deg = '0;
  logic       req_ver_ok = 1'b0;
  logic [9:0] in_reg;
  logic [6:0] out_reg;
  logic       busy;
  logic       done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tapdly_prog u_tapdly_prog (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_in_deg(req_in_deg), .req_out_deg(req_out_deg),
    .req_ver_ok(req_ver_ok), .in_reg(in_reg), .out_reg(out_reg),
    .busy(busy), .done(done)
  );

  function automatic int taps_in(int m);
    if (m == 1 || m == 2 || m == 4 || m == 7 || m == 8) return 120;
    if (m == 5) return 60;
    if (m == 6 || m == 9) return 30;
    return 0;
  endfunction

  function automatic int taps_out(int m);
    if (m == 1 || m == 2 || m == 4 || m == 7 || m == 8) return 30;
    if (m == 5) return 15;
    if (m == 6 || m == 9) return 8;
    return 0;
  endfunction

  function automatic int code_in(int m, int d);
    return ((d * taps_in(m)) / 360) % 256;
  endfunction

  function automatic int code_out(int m, int d);
    return ((d * taps_out(m)) / 360) % 64;
  endfunction

  // Behavioural reference: elapsed edges since acceptance, and register image.
  int m_t = -1;
  int m_ver = 0;
  int m_ic = 0;
  int m_oc = 0;
  int m_in = 0;
  int m_out = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = -1; m_in = 0; m_out = 0;
    end else if (m_t < 0) begin
      if (req_valid) begin
        m_t = 0;
        m_ver = req_ver_ok ? 1 : 0;
        m_ic = code_in(req_mode, req_in_deg);
        m_oc = code_out(req_mode, req_out_deg);
      end
    end else begin
      m_t = m_t + 1;
      if (m_ver != 0) begin
        if (m_t == 18) m_in = m_in | 512;
        if (m_t == 19) m_in = m_in | 256;
        if (m_t == 20) m_in = (m_in & 768) | m_ic;
        if (m_t == 21) m_in = m_in & 511;
        if (m_t == 22) m_out = m_out | 64;
        if (m_t == 23) m_out = (m_out & 64) | m_oc;
      end
      if (m_t == ((m_ver != 0) ? 24 : 18)) m_t = -1;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check("R7 in_reg", int'(in_reg), m_in);
      check("R8 out_reg", int'(out_reg), m_out);
      check("R2 busy", int'(busy), (m_t >= 0) ? 1 : 0);
      check("R2 req_ready", int'(req_ready), (m_t >= 0) ? 0 : 1);
      check("R10 done", int'(done), (m_t == ((m_ver != 0) ? 23 : 17)) ? 1 : 0);
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_t >= 0) @(negedge clk);
  endtask

  task automatic send(int m, int di, int dout, bit v);
    @(negedge clk);
    req_mode = 4'(m); req_in_deg = 9'(di); req_out_deg = 9'(dout); req_ver_ok = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_one(string req, int m, int di, int dout);
    send(m, di, dout, 1'b1);
    wait_idle();
    check(req, int'(in_reg[7:0]), code_in(m, di));
    check(req, int'(out_reg[5:0]), code_out(m, dout));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 in_reg", int'(in_reg), 0);
    check("R1 out_reg", int'(out_reg), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(req_ready), 1);
    rst_n = 1'b1;

    run_one("R3 R4 R6 mode1", 1, 90, 180);   // 30, 15
    run_one("R3 R4 R6 mode5", 5, 359, 359);  // 59, 14
    run_one("R3 R4 R6 mode6", 6, 45, 200);   // 3, 4
    run_one("R3 R4 R6 mode9", 9, 0, 359);    // 0, 7
    run_one("R3 R4 mode7", 7, 300, 12);
    run_one("R3 R4 mode8", 8, 1, 359);
    run_one("R3 R4 mode2", 2, 200, 100);
    check("R7 enable kept", int'(in_reg[9:8]), 1);
    check("R8 enable kept", int'(out_reg[6]), 1);
    run_one("R5 mode3", 3, 100, 100);
    run_one("R5 mode0", 0, 359, 359);
    run_one("R5 mode10", 10, 250, 250);
    run_one("R5 mode15", 15, 359, 359);

    // Sweep every mode code over a few phases.
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) begin
        run_one("R6 sweep", m, (k * 119) % 360, 359 - k * 97);
      end
    end

    // Version flag low: registers keep the previous image.
    run_one("R6 setup", 4, 180, 90);
    send(1, 300, 300, 1'b0);
    wait_idle();
    check("R9 in kept", int'(in_reg[7:0]), code_in(4, 180));
    check("R9 out kept", int'(out_reg[5:0]), code_out(4, 90));

    // Requests while busy are ignored.
    send(4, 240, 60, 1'b1);
    repeat (5) @(negedge clk);
    req_mode = 4'd8; req_in_deg = 9'd10; req_out_deg = 9'd350; req_ver_ok = 1'b1;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    check("R2 ignored in", int'(in_reg[7:0]), code_in(4, 240));
    check("R2 ignored out", int'(out_reg[5:0]), code_out(4, 60));

    // New request held high across the done cycle.
    send(5, 120, 240, 1'b1);
    while (!(m_t == 23)) @(negedge clk);
    check("R10 done cycle", int'(done), 1);
    req_mode = 4'd6; req_in_deg = 9'd333; req_out_deg = 9'd333; req_ver_ok = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    check("R2 not taken at done", int'(busy), 0);
    check("R2 ready after done", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 taken after done", int'(busy), 1);
    wait_idle();
    check("R2 R6 second in", int'(in_reg[7:0]), code_in(6, 333));
    check("R2 R6 second out", int'(out_reg[5:0]), code_out(6, 333));

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule